// File: doc/BRIEF.md
# Serial Receive Channel with DMA Request Signalling

This block is the receive half of an asynchronous serial port. It runs on the system clock and uses a baud tick input that pulses at sixteen times the bit rate. It watches a serial input line, finds and confirms each start bit, and samples the data bits and the optional parity bit. It then checks the stop bit. The start, parity and stop bits are dropped. Only the assembled character goes into storage, together with its parity-error and framing-error flags. Storage is a sixteen-entry queue, or a one-entry holding register when the queue is switched off. A host read strobe removes one character each time it is asserted.

A DMA controller watches an active-low request output. When the queue-enable bit and the DMA-select bit are both set, the request uses burst signalling. The request is raised when the fill reaches a programmable trigger level or when a timeout expires. Once raised, it holds until the storage has drained completely. With any other setting of those two bits, the request is active whenever at least one character is waiting.

Top module: `uart_rx_dma`

## Requirements
- R1: The line is sampled on baud ticks at 16 ticks per bit, through a two-stage synchronizer. A falling edge becomes a start bit only if the line is still low at the half-bit point; a shorter low pulse produces no character. Data bits are taken at their centres, least significant bit first. cfg_data_bits values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits.
- R2: Only the data bits are stored, right-aligned in rd_data, with unused upper bits read as zero. rd_data, rd_parity_err and rd_frame_err show the oldest stored character. A cycle with rd_en high and rd_valid high removes exactly that one character. Without rd_en, no character ever leaves storage.
- R3: With cfg_fifo_en=1, storage holds 16 characters in arrival order. With cfg_fifo_en=0, it holds one character.
- R4: When cfg_parity_en=1, a parity bit follows the data. The parity is even when cfg_parity_odd=0 and odd when cfg_parity_odd=1. A mismatch is stored as rd_parity_err=1 with that character.
- R5: A stop bit sampled low is stored as rd_frame_err=1 with that character. The receiver then waits for the line to return high before it looks for another start bit.
- R6: A character that completes while storage is full is discarded, and rx_overrun goes to 1. rx_overrun returns to 0 on the next rd_en.
- R7: Burst signalling is active only when cfg_fifo_en=1 and cfg_dma_sel=1. All other combinations of these two bits select single signalling.
- R8: With single signalling, dma_rdy_n is 1 while storage is empty and 0 while at least one character is stored.
- R9: With burst signalling, dma_rdy_n goes to 0 when the fill reaches the trigger level. cfg_trig values 0, 1, 2 and 3 select levels of 1, 4, 8 and 14. Below the level and with no timeout, dma_rdy_n stays 1.
- R10: With burst signalling, once dma_rdy_n is 0 it stays 0 until storage is empty, even after the fill drops below the trigger level.
- R11: A timeout occurs when storage is non-empty and no character has been stored or read for 4 character times. One character time is 16 ticks multiplied by the frame length (1 start bit, the data bits, the parity bit if enabled, and 1 stop bit). With burst signalling, a timeout drives dma_rdy_n to 0. The timeout is cleared by the next read.
- R12: After reset, storage is empty, dma_rdy_n is 1 and rx_overrun is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_serial | input | 1 | Serial input line, idle high |
| cfg_data_bits | input | 2 | Data length: 0 to 3 select 5 to 8 bits |
| cfg_parity_en | input | 1 | A parity bit follows the data |
| cfg_parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_fifo_en | input | 1 | 1 selects the 16-entry queue, 0 selects a single holding register |
| cfg_dma_sel | input | 1 | DMA signalling select, combined with cfg_fifo_en |
| cfg_trig | input | 2 | Burst trigger level: 1, 4, 8 or 14 characters |
| rd_en | input | 1 | Host read strobe; removes the oldest character |
| rd_valid | output | 1 | At least one character is stored |
| rd_data | output | 8 | Oldest character, right-aligned |
| rd_parity_err | output | 1 | Parity error flag of the oldest character |
| rd_frame_err | output | 1 | Framing error flag of the oldest character |
| rx_overrun | output | 1 | A character was lost because storage was full |
| dma_rdy_n | output | 1 | DMA request, active low |

## Verification
A character lands in storage about three ticks after the centre of its stop bit. That is the synchronizer delay plus the stop-state register, so it is in place several cycles before the stop bit ends. The bench therefore samples rd_* and dma_rdy_n on the falling edge that ends the stop bit as it drives it. dma_rdy_n is combinational from the fill count, so it is checked on the falling edge after a read, once the read has taken effect. For the timeout, the bench samples well before and well after the 640-tick window that follows the last stored character in 8-bit, no-parity frames. This keeps the check clear of the single-tick uncertainty around the exact moment of expiry.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef struct packed {
      logic [7:0] data;
      logic       perr;
      logic       ferr;
   } rx_char_t;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PARITY,
      RX_STOP,
      RX_BREAK
   } rx_state_e;

   function automatic int unsigned trig_level(input logic [1:0] sel);
      case (sel)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 14;
      endcase
   endfunction

endpackage

// File: rtl/uart_rx_shift.sv
module uart_rx_shift
   import uart_rx_pkg::*;
#(
   parameter int OVS  = 16,
   parameter int SYNC = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tick,
   input  logic     rx_in,
   input  logic [1:0] cfg_bits,
   input  logic     cfg_par_en,
   input  logic     cfg_par_odd,
   output logic     push,
   output rx_char_t push_char
);

   localparam int CW = $clog2(OVS);
   localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OVS - 1);

   logic [SYNC-1:0] sync_q;
   logic            line;

   generate
      if (SYNC == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q <= '1;
            else        sync_q <= rx_in;
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC-2:0], rx_in};
      end
   endgenerate

   assign line = sync_q[SYNC-1];

   rx_state_e       st;
   logic [CW-1:0]   cnt;
   logic [2:0]      bit_idx;
   logic [7:0]      shreg;
   logic            pbit;
   logic [2:0]      last_idx;
   logic [7:0]      aligned;
   logic            par_bad;

   assign last_idx = 3'd4 + {1'b0, cfg_bits};

   always_comb begin
      aligned = shreg >> (4'd3 - {2'b0, cfg_bits});
      par_bad = cfg_par_en && ((^aligned ^ pbit) != cfg_par_odd);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= RX_IDLE;
         cnt       <= '0;
         bit_idx   <= '0;
         shreg     <= '0;
         pbit      <= 1'b0;
         push      <= 1'b0;
         push_char <= '0;
      end else begin
         push <= 1'b0;
         if (tick) begin
            case (st)
               RX_IDLE: begin
                  if (!line) begin
                     st  <= RX_START;
                     cnt <= '0;
                  end
               end
               RX_START: begin
                  if (cnt == MID) begin
                     cnt     <= '0;
                     bit_idx <= '0;
                     shreg   <= '0;
                     st      <= line ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt == LAST) begin
                     cnt   <= '0;
                     shreg <= {line, shreg[7:1]};
                     if (bit_idx == last_idx)
                        st <= cfg_par_en ? RX_PARITY : RX_STOP;
                     else
                        bit_idx <= bit_idx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_PARITY: begin
                  if (cnt == LAST) begin
                     cnt  <= '0;
                     pbit <= line;
                     st   <= RX_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt == LAST) begin
                     cnt            <= '0;
                     push           <= 1'b1;
                     push_char.data <= aligned;
                     push_char.perr <= par_bad;
                     push_char.ferr <= !line;
                     st             <= line ? RX_IDLE : RX_BREAK;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_BREAK: begin
                  if (line) st <= RX_IDLE;
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
   import uart_rx_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     push,
   input  rx_char_t push_char,
   input  logic     pop,
   input  logic     cfg_fifo_en,
   output rx_char_t head,
   output logic [AW:0] count,
   output logic     full,
   output logic     overrun
);

   localparam logic [AW:0] DEPTH_C = (AW + 1)'(DEPTH);

   rx_char_t        mem [DEPTH];
   logic [AW-1:0]   wr_ptr;
   logic [AW-1:0]   rd_ptr;
   logic            do_push;
   logic            do_pop;

   assign full    = cfg_fifo_en ? (count == DEPTH_C) : (count != '0);
   assign do_push = push && !full;
   assign do_pop  = pop && (count != '0);
   assign head    = mem[rd_ptr];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk)
            if (do_push && (wr_ptr == AW'(g))) mem[g] <= push_char;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count   <= '0;
         overrun <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (push && full) overrun <= 1'b1;
         else if (pop)     overrun <= 1'b0;
      end
   end

endmodule

// File: rtl/uart_rx_rdy.sv
module uart_rx_rdy
   import uart_rx_pkg::*;
#(
   parameter int OVS       = 16,
   parameter int TMO_CHARS = 4,
   parameter int CNT_W     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] count,
   input  logic             push,
   input  logic             pop,
   input  logic             cfg_fifo_en,
   input  logic             cfg_dma_sel,
   input  logic [1:0]       cfg_trig,
   input  logic [1:0]       cfg_bits,
   input  logic             cfg_par_en,
   output logic             dma_rdy_n
);

   localparam int TW = $clog2(TMO_CHARS * OVS * 11 + 1);

   logic [TW-1:0]    limit;
   logic [TW-1:0]    tcnt;
   logic             tmo;
   logic             burst_q;
   logic             burst_mode;
   logic             reached;
   logic             stored;
   logic [CNT_W-1:0] lvl;

   assign limit      = TW'(TMO_CHARS * OVS) * (TW'(7) + TW'(cfg_bits) + TW'(cfg_par_en));
   assign burst_mode = cfg_fifo_en && cfg_dma_sel;
   assign stored     = (count != '0);
   assign lvl        = CNT_W'(trig_level(cfg_trig));
   assign reached    = (count >= lvl) || tmo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt <= '0;
         tmo  <= 1'b0;
      end else if (!stored || pop) begin
         tcnt <= '0;
         tmo  <= 1'b0;
      end else if (push) begin
         tcnt <= '0;
      end else if (tick && !tmo) begin
         if (tcnt >= limit - 1'b1) tmo  <= 1'b1;
         else                      tcnt <= tcnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) burst_q <= 1'b0;
      else        burst_q <= burst_mode && stored && (burst_q || reached);

   assign dma_rdy_n = burst_mode ? !(stored && (burst_q || reached)) : !stored;

endmodule

// File: rtl/uart_rx_dma.sv
module uart_rx_dma
   import uart_rx_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int OVS       = 16,
   parameter int SYNC      = 2,
   parameter int TMO_CHARS = 4,
   localparam int CNT_W    = $clog2(DEPTH) + 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick,
   input  logic       rx_serial,
   input  logic [1:0] cfg_data_bits,
   input  logic       cfg_parity_en,
   input  logic       cfg_parity_odd,
   input  logic       cfg_fifo_en,
   input  logic       cfg_dma_sel,
   input  logic [1:0] cfg_trig,
   input  logic       rd_en,
   output logic       rd_valid,
   output logic [7:0] rd_data,
   output logic       rd_parity_err,
   output logic       rd_frame_err,
   output logic       rx_overrun,
   output logic       dma_rdy_n
);

   generate
      if (DEPTH < 14 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 14");
      end
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (SYNC < 1) begin : g_bad_sync
         $error("SYNC must be at least 1");
      end
   endgenerate

   logic             fifo_push;
   rx_char_t         fifo_in;
   rx_char_t         fifo_head;
   logic [CNT_W-1:0] count;
   logic             fifo_full;
   logic             pop;

   assign rd_valid      = (count != '0);
   assign pop           = rd_en && rd_valid;
   assign rd_data       = fifo_head.data;
   assign rd_parity_err = fifo_head.perr;
   assign rd_frame_err  = fifo_head.ferr;

   uart_rx_shift #(.OVS(OVS), .SYNC(SYNC)) i_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (baud_tick),
      .rx_in      (rx_serial),
      .cfg_bits   (cfg_data_bits),
      .cfg_par_en (cfg_parity_en),
      .cfg_par_odd(cfg_parity_odd),
      .push       (fifo_push),
      .push_char  (fifo_in)
   );

   uart_rx_fifo #(.DEPTH(DEPTH)) i_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (fifo_push),
      .push_char  (fifo_in),
      .pop        (pop),
      .cfg_fifo_en(cfg_fifo_en),
      .head       (fifo_head),
      .count      (count),
      .full       (fifo_full),
      .overrun    (rx_overrun)
   );

   uart_rx_rdy #(.OVS(OVS), .TMO_CHARS(TMO_CHARS), .CNT_W(CNT_W)) i_rdy (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (baud_tick),
      .count      (count),
      .push       (fifo_push),
      .pop        (pop),
      .cfg_fifo_en(cfg_fifo_en),
      .cfg_dma_sel(cfg_dma_sel),
      .cfg_trig   (cfg_trig),
      .cfg_bits   (cfg_data_bits),
      .cfg_par_en (cfg_parity_en),
      .dma_rdy_n  (dma_rdy_n)
   );

endmodule

// File: rtl/uart_rx_dma_chk.sv
module uart_rx_dma_chk
   import uart_rx_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count,
   input logic             fifo_push,
   input logic             fifo_full,
   input logic             rd_en,
   input logic             rd_valid,
   input logic             dma_rdy_n,
   input logic             rx_overrun,
   input logic             cfg_fifo_en,
   input logic             cfg_dma_sel,
   input logic [1:0]       cfg_trig
);

   logic burst_mode;
   assign burst_mode = cfg_fifo_en && cfg_dma_sel;

   AST_EMPTY_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> dma_rdy_n);  // R8

   AST_SINGLE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!burst_mode && rd_valid) |-> !dma_rdy_n);  // R7

   AST_TRIG_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_mode && count >= CNT_W'(trig_level(cfg_trig))) |-> !dma_rdy_n);  // R9

   AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_mode && $past(burst_mode) && $past(!dma_rdy_n) && rd_valid) |-> !dma_rdy_n);  // R10

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));  // R3

   AST_HOLD_REG_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_fifo_en && $past(!cfg_fifo_en) && $past(count <= 1)) |-> count <= 1);  // R3

   AST_POP_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_en) |-> count >= $past(count));  // R2

   AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fifo_push && fifo_full) |-> rx_overrun);  // R6

endmodule

bind uart_rx_dma uart_rx_dma_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .count      (count),
   .fifo_push  (fifo_push),
   .fifo_full  (fifo_full),
   .rd_en      (rd_en),
   .rd_valid   (rd_valid),
   .dma_rdy_n  (dma_rdy_n),
   .rx_overrun (rx_overrun),
   .cfg_fifo_en(cfg_fifo_en),
   .cfg_dma_sel(cfg_dma_sel),
   .cfg_trig   (cfg_trig)
);

// File: tb/test_uart_rx_dma.sv
`timescale 1ns/1ps
module test_uart_rx_dma;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b1;
   logic       rx_serial = 1'b1;
   logic [1:0] cfg_data_bits = 2'd3;
   logic       cfg_parity_en = 1'b0;
   logic       cfg_parity_odd = 1'b0;
   logic       cfg_fifo_en = 1'b1;
   logic       cfg_dma_sel = 1'b0;
   logic [1:0] cfg_trig = 2'd0;
   logic       rd_en = 1'b0;
   logic       rd_valid;
   logic [7:0] rd_data;
   logic       rd_parity_err;
   logic       rd_frame_err;
   logic       rx_overrun;
   logic       dma_rdy_n;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   uart_rx_dma i_uart_rx_dma (
      .clk           (clk),
      .rst_n         (rst_n),
      .baud_tick     (baud_tick),
      .rx_serial     (rx_serial),
      .cfg_data_bits (cfg_data_bits),
      .cfg_parity_en (cfg_parity_en),
      .cfg_parity_odd(cfg_parity_odd),
      .cfg_fifo_en   (cfg_fifo_en),
      .cfg_dma_sel   (cfg_dma_sel),
      .cfg_trig      (cfg_trig),
      .rd_en         (rd_en),
      .rd_valid      (rd_valid),
      .rd_data       (rd_data),
      .rd_parity_err (rd_parity_err),
      .rd_frame_err  (rd_frame_err),
      .rx_overrun    (rx_overrun),
      .dma_rdy_n     (dma_rdy_n)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive_bit(input logic v);
      @(negedge clk) rx_serial = v;
      repeat (15) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                             input bit odd, input bit bad_par, input bit bad_stop);
      logic [7:0] m;
      m = 8'((9'd1 << nb) - 1);
      drive_bit(1'b0);
      for (int i = 0; i < nb; i++) drive_bit(d[i]);
      if (pen) drive_bit((^(d & m)) ^ odd ^ bad_par);
      drive_bit(!bad_stop);
      if (bad_stop) drive_bit(1'b1);
   endtask

   task automatic pop;
      @(negedge clk) rd_en = 1'b1;
      @(negedge clk) rd_en = 1'b0;
   endtask

   task automatic set_mode(input bit fen, input bit dsel, input logic [1:0] trig);
      @(negedge clk);
      cfg_fifo_en = fen;
      cfg_dma_sel = dsel;
      cfg_trig    = trig;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] pats [5];
      logic [7:0] m;
      int lv;
      pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
      pats[3] = 8'h3C; pats[4] = 8'h5A;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 rd_valid after reset", rd_valid, 0);
      chk("R12 dma_rdy_n after reset", dma_rdy_n, 1);
      chk("R12 rx_overrun after reset", rx_overrun, 0);

      // R1 short low pulse is rejected
      @(negedge clk) rx_serial = 1'b0;
      repeat (5) @(negedge clk);
      rx_serial = 1'b1;
      repeat (40) @(negedge clk);
      chk("R1 glitch gives no character", rd_valid, 0);

      // R1 R2 R4 R8 sweep over length, parity and data, single signalling
      for (int nb = 5; nb <= 8; nb++) begin
         for (int pm = 0; pm < 3; pm++) begin
            for (int k = 0; k < 5; k++) begin
               @(negedge clk);
               cfg_data_bits  = 2'(nb - 5);
               cfg_parity_en  = (pm != 0);
               cfg_parity_odd = (pm == 2);
               m = 8'((9'd1 << nb) - 1);
               send_frame(pats[k], nb, pm != 0, pm == 2, 1'b0, 1'b0);
               chk("R1 R2 character stored", rd_valid, 1);
               chk("R2 data right-aligned", rd_data, pats[k] & m);
               chk("R4 no parity error", rd_parity_err, 0);
               chk("R5 no framing error", rd_frame_err, 0);
               chk("R8 request active with data", dma_rdy_n, 0);
               pop();
               chk("R8 request inactive when empty", dma_rdy_n, 1);
            end
         end
      end

      // R4 parity mismatch, even and odd
      for (int pm = 1; pm < 3; pm++) begin
         @(negedge clk);
         cfg_data_bits = 2'd3; cfg_parity_en = 1'b1; cfg_parity_odd = (pm == 2);
         send_frame(8'h96, 8, 1'b1, pm == 2, 1'b1, 1'b0);
         chk("R4 parity error flagged", rd_parity_err, 1);
         chk("R4 data kept with parity error", rd_data, 8'h96);
         pop();
      end

      // R5 stop bit low
      @(negedge clk) cfg_parity_en = 1'b0;
      send_frame(8'h71, 8, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R5 framing error flagged", rd_frame_err, 1);
      chk("R5 data kept with framing error", rd_data, 8'h71);
      repeat (40) @(negedge clk);
      pop();
      chk("R5 no extra character after low stop", rd_valid, 0);

      // R3 R6 queue capacity and overrun
      for (int i = 0; i < 17; i++) send_frame(8'(i * 7 + 3), 8, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R6 overrun set", rx_overrun, 1);
      for (int i = 0; i < 16; i++) begin
         chk("R3 queue order", rd_data, (i * 7 + 3) & 8'hFF);
         pop();
         if (i == 0) chk("R6 overrun cleared by read", rx_overrun, 0);
      end
      chk("R3 queue held 16", rd_valid, 0);

      // R3 R7 holding register, select bit alone gives single signalling
      set_mode(1'b0, 1'b1, 2'd3);
      send_frame(8'h11, 8, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R7 single signalling with queue off", dma_rdy_n, 0);
      send_frame(8'h22, 8, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R3 holding register overrun", rx_overrun, 1);
      chk("R3 holding register keeps first", rd_data, 8'h11);
      pop();
      chk("R3 holding register one entry", rd_valid, 0);

      // R7 queue on, select off, high trigger: still single
      set_mode(1'b1, 1'b0, 2'd3);
      send_frame(8'h33, 8, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R7 single signalling with select off", dma_rdy_n, 0);
      pop();

      // R9 R10 burst signalling at every trigger level
      for (int t = 0; t < 4; t++) begin
         set_mode(1'b1, 1'b1, 2'(t));
         lv = (t == 0) ? 1 : (t == 1) ? 4 : (t == 2) ? 8 : 14;
         for (int i = 0; i < lv - 1; i++) send_frame(8'(i), 8, 1'b0, 1'b0, 1'b0, 1'b0);
         if (lv > 1) chk("R9 inactive below trigger", dma_rdy_n, 1);
         send_frame(8'hEE, 8, 1'b0, 1'b0, 1'b0, 1'b0);
         chk("R9 active at trigger", dma_rdy_n, 0);
         for (int i = 0; i < lv - 1; i++) begin
            pop();
            chk("R10 held until empty", dma_rdy_n, 0);
         end
         pop();
         chk("R10 released when empty", dma_rdy_n, 1);
      end

      // R11 timeout in burst signalling, trigger 14, 8N1 gives 640 ticks
      set_mode(1'b1, 1'b1, 2'd3);
      send_frame(8'h01, 8, 1'b0, 1'b0, 1'b0, 1'b0);
      send_frame(8'h02, 8, 1'b0, 1'b0, 1'b0, 1'b0);
      repeat (600) @(negedge clk);
      chk("R11 no timeout before 4 characters", dma_rdy_n, 1);
      repeat (60) @(negedge clk);
      chk("R11 timeout raises request", dma_rdy_n, 0);
      pop();
      chk("R10 held after timeout read", dma_rdy_n, 0);
      pop();
      chk("R10 released after drain", dma_rdy_n, 1);
      send_frame(8'h03, 8, 1'b0, 1'b0, 1'b0, 1'b0);
      repeat (600) @(negedge clk);
      chk("R11 timeout cleared by read", dma_rdy_n, 1);
      repeat (60) @(negedge clk);
      chk("R11 timeout again after idle", dma_rdy_n, 0);
      pop();

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule